// File: doc/BRIEF.md
# Paged DMA Address Translator

This block sits between a network controller's DMA engine and a small shared RAM. The controller issues 24-bit addresses. The translator drops the top four bits and uses the next ten bits to pick one slot out of a 1024-entry page map. It then joins the physical frame number stored in that slot to the 10-bit byte offset. The result is a physical RAM address, which is registered one cycle after the controller's address strobe.

Each map entry also carries two selects. One chooses the byte lane order for the page. The other says whether the page lives in on-board RAM or on a secondary memory bus. Both selects appear on the output next to the address. When a page is marked as controller (little-endian) order, the translator swaps the two bytes of a 16-bit word in both directions, or flips address bit 0 for a byte access.

A host register port writes and reads map entries. The top slot, which covers the controller's fixed startup pointer near the top of its address space, can be loaded with any frame so that it aliases a low page. A lookup that points past on-board RAM sets a sticky out-of-range flag.

Top module: `pgxlat_top`

## Requirements
- R1: After reset, `phys_valid` and `oor_flag` are 0 and every map entry reads back as 0.
- R2: A host write of `host_wdata` to slot `host_idx` is stored. A host read of slot `host_idx` presents that entry on `host_rdata` one cycle after `host_rd_en`.
- R3: One cycle after `ctl_strobe`, `phys_valid` is 1 and `phys_addr` equals {frame, `ctl_addr[9:0]`}. The frame is entry bits 11:0 of slot `ctl_addr[19:10]`, and `ctl_addr[23:20]` has no effect. Without a strobe, `phys_valid` is 0 in the next cycle.
- R4: Address 0xFFFFF4 is translated through slot 1023, so that slot can alias any low frame.
- R5: `phys_host_order` reports entry bit 15, and `phys_secondary` reports entry bit 13, of the slot that was looked up.
- R6: For a 16-bit access (`ctl_byte`=0), `phys_wdata` is `ctl_wdata` with its two bytes swapped when entry bit 15 is 0. It is passed through unchanged when bit 15 is 1.
- R7: `ctl_rdata` is `ram_rdata` with its bytes swapped when the last lookup was a 16-bit access with bit 15 clear. Otherwise it is unchanged.
- R8: For a byte access (`ctl_byte`=1), `phys_addr[0]` is inverted when entry bit 15 is 0, and the data is not swapped.
- R9: A lookup whose frame is 256 or above while entry bit 13 is 0 sets `oor_flag`, which then stays set until reset. A frame of 256 or above with bit 13 set does not set it.
- R10: A map write takes effect for the next lookup. A lookup in the same cycle as a write to its slot uses the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host map write strobe |
| host_rd_en | input | 1 | Host map read strobe |
| host_idx | input | 10 | Map slot for host access |
| host_wdata | input | 16 | Map entry to write |
| host_rdata | output | 16 | Map entry read back |
| ctl_strobe | input | 1 | Controller address valid |
| ctl_addr | input | 24 | Controller address |
| ctl_byte | input | 1 | 1 = byte access, 0 = 16-bit access |
| ctl_wdata | input | 16 | Controller write data |
| ram_rdata | input | 16 | Data read from RAM |
| ctl_rdata | output | 16 | Read data toward controller, lane-corrected |
| phys_valid | output | 1 | Translated address valid |
| phys_addr | output | 22 | Frame number and page offset |
| phys_host_order | output | 1 | Page uses host byte order |
| phys_secondary | output | 1 | Page lives on the secondary bus |
| phys_wdata | output | 16 | Write data toward RAM, lane-corrected |
| oor_flag | output | 1 | Sticky out-of-range flag |

## Verification
Random map entries cover every combination of the order bit, the bus bit and large or small frames. Random lookups aimed at written slots, with random top nibbles, check that the index, the offset and the ignored bits are decoded correctly. Byte and word accesses are mixed, which separates the bit 0 flip from the data swap. Directed cases cover the startup pointer address through slot 1023, a write and a lookup to the same slot in the same cycle, and a secondary-bus frame that must not set the out-of-range flag.

// File: rtl/pgxlat_pkg.sv
package pgxlat_pkg;
    parameter int ADDR_W        = 24;
    parameter int OFS_W         = 10;
    parameter int IDX_W         = 10;
    parameter int FRAME_W       = 12;
    parameter int DATA_W        = 16;
    parameter int ONBOARD_PAGES = 256;
    parameter int BIT_HORDER    = 15;
    parameter int BIT_SECOND    = 13;
    localparam int PA_W      = FRAME_W + OFS_W;
    localparam int MAP_DEPTH = 1 << IDX_W;

    typedef logic [DATA_W-1:0] entry_t;

    typedef struct packed {
        logic              valid;
        logic [PA_W-1:0]   addr;
        logic              horder;
        logic              second;
        logic              byte_acc;
        logic [DATA_W-1:0] wdata;
        logic              oor;
    } xlat_state_t;
endpackage

// File: rtl/pgxlat_map.sv
module pgxlat_map
    import pgxlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output entry_t           rd_data,
    input  logic [IDX_W-1:0] lk_idx,
    output entry_t           lk_entry
);
    entry_t map_q [MAP_DEPTH];
    entry_t map_d [MAP_DEPTH];
    entry_t rdata_q, rdata_d;

    always_comb begin
        for (int i = 0; i < MAP_DEPTH; i++) map_d[i] = map_q[i];
        rdata_d = rdata_q;
        if (wr_en) map_d[wr_idx] = wr_data;
        if (rd_en) rdata_d = map_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAP_DEPTH; i++) map_q[i] <= '0;
            rdata_q <= '0;
        end else begin
            for (int i = 0; i < MAP_DEPTH; i++) map_q[i] <= map_d[i];
            rdata_q <= rdata_d;
        end
    end

    assign rd_data  = rdata_q;
    assign lk_entry = map_q[lk_idx];

    // R2: a written entry is held in its slot on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> map_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/pgxlat_lane.sv
module pgxlat_lane
    import pgxlat_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  logic              swap,
    output logic [DATA_W-1:0] dout
);
    localparam int NB = DATA_W / 8;
    logic [DATA_W-1:0] rev;

    for (genvar k = 0; k < NB; k++) begin : g_byte
        assign rev[k*8 +: 8] = din[(NB-1-k)*8 +: 8];
    end

    assign dout = swap ? rev : din;
endmodule

// File: rtl/pgxlat_lookup.sv
module pgxlat_lookup
    import pgxlat_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_acc,
    input  entry_t            entry,
    output logic [IDX_W-1:0]  idx,
    output logic [PA_W-1:0]   paddr,
    output logic              horder,
    output logic              second,
    output logic              oor_hit
);
    logic [FRAME_W-1:0] frame;
    logic [OFS_W-1:0]   ofs;

    always_comb begin
        idx    = addr[OFS_W +: IDX_W];
        ofs    = addr[OFS_W-1:0];
        frame  = entry[FRAME_W-1:0];
        horder = entry[BIT_HORDER];
        second = entry[BIT_SECOND];
        paddr  = {frame, ofs};
        if (byte_acc && !horder) paddr[0] = ~ofs[0];
        oor_hit = !second && (frame >= FRAME_W'(ONBOARD_PAGES));
    end
endmodule

// File: rtl/pgxlat_top.sv
module pgxlat_top
    import pgxlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic [9:0]        host_idx,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic              ctl_strobe,
    input  logic [23:0]       ctl_addr,
    input  logic              ctl_byte,
    input  logic [15:0]       ctl_wdata,
    input  logic [15:0]       ram_rdata,
    output logic [15:0]       ctl_rdata,
    output logic              phys_valid,
    output logic [21:0]       phys_addr,
    output logic              phys_host_order,
    output logic              phys_secondary,
    output logic [15:0]       phys_wdata,
    output logic              oor_flag
);
    xlat_state_t st_q, st_d;

    logic [IDX_W-1:0]  lk_idx;
    entry_t            lk_entry;
    logic [PA_W-1:0]   lk_paddr;
    logic              lk_horder, lk_second, lk_oor;
    logic [DATA_W-1:0] wdata_lane;

    pgxlat_map u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr_en),
        .wr_idx   (host_idx),
        .wr_data  (host_wdata),
        .rd_en    (host_rd_en),
        .rd_idx   (host_idx),
        .rd_data  (host_rdata),
        .lk_idx   (lk_idx),
        .lk_entry (lk_entry)
    );

    pgxlat_lookup u_lookup (
        .addr     (ctl_addr),
        .byte_acc (ctl_byte),
        .entry    (lk_entry),
        .idx      (lk_idx),
        .paddr    (lk_paddr),
        .horder   (lk_horder),
        .second   (lk_second),
        .oor_hit  (lk_oor)
    );

    pgxlat_lane u_wlane (
        .din  (ctl_wdata),
        .swap (!ctl_byte && !lk_horder),
        .dout (wdata_lane)
    );

    pgxlat_lane u_rlane (
        .din  (ram_rdata),
        .swap (!st_q.byte_acc && !st_q.horder),
        .dout (ctl_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = ctl_strobe;
        if (ctl_strobe) begin
            st_d.addr     = lk_paddr;
            st_d.horder   = lk_horder;
            st_d.second   = lk_second;
            st_d.byte_acc = ctl_byte;
            st_d.wdata    = wdata_lane;
            st_d.oor      = st_q.oor | lk_oor;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phys_valid      = st_q.valid;
    assign phys_addr       = st_q.addr;
    assign phys_host_order = st_q.horder;
    assign phys_secondary  = st_q.second;
    assign phys_wdata      = st_q.wdata;
    assign oor_flag        = st_q.oor;

    // R9: once set, the out-of-range flag never clears
    a_r9_oor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        oor_flag |=> oor_flag);
    // R3: page offset bits above bit 0 pass straight through
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_strobe |=> phys_addr[OFS_W-1:1] == $past(ctl_addr[OFS_W-1:1]));
    // R3: no strobe, no valid address
    a_r3_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_strobe |=> !phys_valid);
    // R6: host-order word writes are not swapped
    a_r6_host_order_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_strobe && !ctl_byte && lk_entry[BIT_HORDER]) |=> phys_wdata == $past(ctl_wdata));
endmodule

// File: tb/pgxlat_top_tb_top.sv
module pgxlat_top_tb_top;
    logic clk = 0;
    logic rst_n = 0;
    logic host_wr_en = 0, host_rd_en = 0;
    logic [9:0] host_idx = 0;
    logic [15:0] host_wdata = 0, host_rdata;
    logic ctl_strobe = 0, ctl_byte = 0;
    logic [23:0] ctl_addr = 0;
    logic [15:0] ctl_wdata = 0, ram_rdata = 0, ctl_rdata, phys_wdata;
    logic phys_valid, phys_host_order, phys_secondary, oor_flag;
    logic [21:0] phys_addr;

    int n_chk = 0, n_fail = 0;
    logic [15:0] model [1024];
    logic model_oor = 0;
    logic [9:0] used [8];

    always #5 clk = ~clk;

    pgxlat_top dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] swp(input logic [15:0] d);
        return {d[7:0], d[15:8]};
    endfunction

    task automatic host_write(input logic [9:0] i, input logic [15:0] d);
        @(negedge clk);
        host_wr_en = 1; host_idx = i; host_wdata = d;
        @(negedge clk);
        host_wr_en = 0;
        model[i] = d;
    endtask

    task automatic host_read(input logic [9:0] i);
        @(negedge clk);
        host_rd_en = 1; host_idx = i;
        @(negedge clk);
        host_rd_en = 0;
        chk("R2 map readback", 32'(host_rdata), 32'(model[i]));
    endtask

    task automatic lookup(input logic [23:0] a, input logic by, input logic [15:0] wd,
                          input logic [15:0] e);
        logic [21:0] pa;
        logic [15:0] rd;
        rd = 16'($urandom);
        pa = {e[11:0], a[9:0]};
        if (by && !e[15]) pa[0] = ~pa[0];
        if (!e[13] && e[11:0] >= 12'd256) model_oor = 1;
        @(negedge clk);
        ctl_strobe = 1; ctl_addr = a; ctl_byte = by; ctl_wdata = wd; ram_rdata = rd;
        @(negedge clk);
        ctl_strobe = 0;
        chk("R3 valid", 32'(phys_valid), 1);
        chk(by ? "R8 byte addr" : "R3 addr", 32'(phys_addr), 32'(pa));
        chk("R5 order", 32'(phys_host_order), 32'(e[15]));
        chk("R5 bus", 32'(phys_secondary), 32'(e[13]));
        chk("R6 wdata", 32'(phys_wdata), 32'((!by && !e[15]) ? swp(wd) : wd));
        chk("R7 rdata", 32'(ctl_rdata), 32'((!by && !e[15]) ? swp(rd) : rd));
        chk("R9 oor", 32'(oor_flag), 32'(model_oor));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", 32'(phys_valid), 0);
        chk("R1 oor", 32'(oor_flag), 0);
        host_read(10'd1023);
        host_read(10'd37);
        // R1/R3: empty map gives frame 0, top nibble ignored
        lookup(24'hA00C85, 0, 16'h1234, 16'h0000);
        @(negedge clk);
        chk("R3 idle", 32'(phys_valid), 0);
        // R4: startup pointer through slot 1023 aliases frame 0 in host order
        host_write(10'd1023, 16'h8000);
        lookup(24'hFFFFF4, 0, 16'hBEEF, model[1023]);
        chk("R4 alias", 32'(phys_addr), 32'h0003F4);
        // R8: byte access, controller order flips bit 0
        host_write(10'd4, 16'h0005);
        lookup(24'h001002, 1, 16'h00AA, model[4]);
        chk("R8 flip", 32'(phys_addr[0]), 1);
        // R9: large frame on secondary bus does not set the flag
        host_write(10'd6, 16'h2300);
        lookup(24'h001800, 0, 16'h5A5A, model[6]);
        chk("R9 secondary ok", 32'(oor_flag), 0);
        // R10: same-cycle write and lookup uses the old entry
        @(negedge clk);
        host_wr_en = 1; host_idx = 10'd4; host_wdata = 16'h8077;
        ctl_strobe = 1; ctl_addr = 24'h001010; ctl_byte = 0; ctl_wdata = 16'h1111;
        @(negedge clk);
        host_wr_en = 0; ctl_strobe = 0;
        chk("R10 old entry", 32'(phys_addr), 32'({12'h005, 10'h010}));
        model[4] = 16'h8077;
        lookup(24'h001010, 0, 16'h1111, model[4]);
        chk("R10 new entry", 32'(phys_addr), 32'({12'h077, 10'h010}));
        // random phase
        for (int i = 0; i < 8; i++) begin
            used[i] = 10'($urandom);
            host_write(used[i], 16'($urandom) & 16'hA0FF);
        end
        for (int n = 0; n < 300; n++) begin
            int sel;
            sel = int'($urandom % 8);
            if ($urandom % 6 == 0) begin
                logic [15:0] e;
                e = 16'($urandom);
                if ($urandom % 3 != 0) e[11:8] = 4'h0;
                host_write(used[sel], e);
            end else if ($urandom % 8 == 0) begin
                host_read(used[sel]);
            end else begin
                logic [23:0] a;
                a = {4'($urandom), used[sel], 10'($urandom)};
                lookup(a, 1'($urandom), 16'($urandom), model[used[sel]]);
            end
        end
        // R9: an out-of-range frame on board memory sets the sticky flag
        host_write(10'd9, 16'h0100);
        lookup(24'h002400, 0, 16'h0F0F, model[9]);
        host_write(10'd9, 16'h0001);
        lookup(24'h002400, 0, 16'h0F0F, model[9]);
        chk("R9 sticky", 32'(oor_flag), 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule